// File: doc/BRIEF.md
# Read Data Latency Pipeline

This block is the read side of a synchronous DRAM column path. A registered command strobe carries either a READ or a WRITE together with a starting column. A READ produces a burst of words from a small internal array. The first word appears a programmable number of clocks after the command: the latency is 2 or 3 and is set by a 3-bit latency code. Later words follow on consecutive clocks, with the column advancing inside an aligned block.

A per-lane mask input gates read data through its own fixed two-register pipeline. The same mask suppresses lanes of a WRITE at once. A new READ may arrive on any cycle. It cuts the current burst short and continues the data stream without a bubble. A WRITE blanks the bus at once and drops any READ still waiting for its latency.

Top module: `sdr_cas_read_path`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `dqOe` is all zero and `dqOut` is zero. The latency defaults to 2.
- R2: A READ registered at edge n with latency m drives its first word, with `dqOe` high, from edge n+m-1 onward, so the word is valid at edge n+m. Before that edge `dqOe` stays low. Latency code 3'b010 selects 2 and code 3'b011 selects 3.
- R3: Any other latency code is reserved. While it is applied, the latency stays at the last legal value.
- R4: A burst has BURST_LEN (4) words on consecutive clocks. Word k reads column {start[3:2], start[1:0]+k mod 4}, so the burst wraps within an aligned block of four.
- R5: When the last word of a burst has been driven and no newer READ is pending, `dqOe` returns to zero on the next edge.
- R6: A READ registered while a burst is running truncates it. The new first word directly follows the last word driven from the old burst, with no idle cycle.
- R7: Each READ keeps the latency in force at the edge that registered it. A later change of code does not move a READ that is already in flight.
- R8: A mask bit sampled high at edge e disables that lane (`dqOe` bit low, data zero) for the word driven from edge e+1. A mask bit sampled low at edge e lets that word through.
- R9: A WRITE writes `wrData` into column `cmdCol` at the edge that registers it. Only lanes whose mask bit is low at that same edge are written; masked lanes keep their old byte.
- R10: A WRITE registered at edge w sets `dqOe` to zero from edge w onward, whatever the mask. It also cancels every READ still waiting for its latency.
- R11: After reset, byte lane l of column c holds the value 16*l + c (modulo 256).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| cmdValid | input | 1 | A command is registered on this edge |
| cmdWrite | input | 1 | Command type: 1 = WRITE, 0 = READ |
| cmdCol | input | COL_W | Starting column of a READ, or target column of a WRITE |
| casCode | input | 3 | Latency code: 010 selects 2, 011 selects 3, other codes are reserved |
| dqm | input | LANES | Per-lane mask |
| wrData | input | 8*LANES | Data written by a WRITE |
| dqOut | output | 8*LANES | Registered read data |
| dqOe | output | LANES | Registered per-lane output enable |

## Verification
The latency delay line and the burst sequencer are hidden state. Any error in them shows at the ports within one to three clocks as one of three symptoms: an enable that is early, late or missing; a word from the wrong column; or a stream with a bubble or an overlap where a truncating READ hands over. A lost or stale mask bit disables the wrong word, exactly one clock after the intended one. A READ that survives a WRITE brings `dqOe` back up after the bus should have gone quiet. A corrupted array entry shows up as a wrong byte the next time a burst reads that column.

// File: rtl/sdr_rd_pkg.sv
package sdr_rd_pkg;

  // Legal latency values and their codes
  localparam int unsigned CAS_MIN = 2;
  localparam int unsigned CAS_MAX = 3;
  localparam logic [2:0] CAS_CODE_2 = 3'b010;
  localparam logic [2:0] CAS_CODE_3 = 3'b011;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic fire;  // drive one word this edge
    logic kill;  // blank the bus this edge
    logic wrEn;  // masked array write this edge
  } rdStrobe_t;

endpackage

// File: rtl/sdr_rd_ctrl.sv
module sdr_rd_ctrl
  import sdr_rd_pkg::*;
#(
  parameter int COL_W     = 4,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic             cmdWrite,
  input  logic [COL_W-1:0] cmdCol,
  input  logic [2:0]       casCode,
  output rdStrobe_t        strb,
  output logic [COL_W-1:0] rdCol
);

  localparam int BW      = $clog2(BURST_LEN);
  localparam int SLOTS   = CAS_MAX - 1;
  localparam int SLOT_IW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [BW-1:0] LAST_BEAT = BW'(BURST_LEN - 1);

  logic rdReq, wrReq;
  assign rdReq = cmdValid & ~cmdWrite;
  assign wrReq = cmdValid &  cmdWrite;

  // Latency selection: a legal code applies at the same edge, a reserved one holds
  logic latIs3, effLat3, codeLegal;
  assign codeLegal = (casCode == CAS_CODE_2) || (casCode == CAS_CODE_3);
  assign effLat3   = codeLegal ? (casCode == CAS_CODE_3) : latIs3;

  always_ff @(posedge clk) begin
    if (!rstN)          latIs3 <= 1'b0;
    else if (codeLegal) latIs3 <= (casCode == CAS_CODE_3);
  end

  // Command delay line: slot i launches after i more edges
  logic [SLOTS-1:0]            slotV, nxtV;
  logic [SLOTS-1:0][COL_W-1:0] slotCol, nxtCol;
  logic [SLOT_IW-1:0]          insIdx;

  assign insIdx = effLat3 ? SLOT_IW'(CAS_MAX - CAS_MIN) : SLOT_IW'(0);

  always_comb begin
    nxtV   = {1'b0, slotV[SLOTS-1:1]};
    nxtCol = {{COL_W{1'b0}}, slotCol[SLOTS-1:1]};
    if (wrReq) begin
      nxtV = '0;
    end else if (rdReq) begin
      nxtV[insIdx]   = 1'b1;   // the newer READ wins a shared slot
      nxtCol[insIdx] = cmdCol;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotV   <= '0;
      slotCol <= '0;
    end else begin
      slotV   <= nxtV;
      slotCol <= nxtCol;
    end
  end

  // Burst sequencer
  logic             launch, active;
  logic [COL_W-1:0] baseCol, seqCol;
  logic [BW-1:0]    beat;

  assign launch = slotV[0] & ~wrReq;
  assign seqCol = {baseCol[COL_W-1:BW], baseCol[BW-1:0] + beat};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      baseCol <= '0;
      beat    <= '0;
    end else if (wrReq) begin
      active <= 1'b0;
    end else if (launch) begin
      active  <= 1'b1;
      baseCol <= slotCol[0];
      beat    <= BW'(1);
    end else if (active) begin
      beat <= beat + BW'(1);
      if (beat == LAST_BEAT) active <= 1'b0;
    end
  end

  assign rdCol     = launch ? slotCol[0] : seqCol;
  assign strb.fire = launch | (active & ~wrReq);
  assign strb.kill = wrReq;
  assign strb.wrEn = wrReq;

endmodule

// File: rtl/sdr_rd_data.sv
module sdr_rd_data
  import sdr_rd_pkg::*;
#(
  parameter int COL_W = 4,
  parameter int LANES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  rdStrobe_t          strb,
  input  logic [COL_W-1:0]   rdCol,
  input  logic [COL_W-1:0]   wrCol,
  input  logic [LANES*8-1:0] wrData,
  input  logic [LANES-1:0]   dqm,
  output logic [LANES*8-1:0] dqOut,
  output logic [LANES-1:0]   dqOe
);

  localparam int DEPTH = 1 << COL_W;

  logic [7:0]       mem [DEPTH][LANES];
  logic [LANES-1:0] mskD1;

  // Array: computed reset image, masked single-word writes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < DEPTH; c++)
        for (int l = 0; l < LANES; l++)
          mem[c][l] <= 8'(l * 16 + c);
    end else if (strb.wrEn) begin
      for (int l = 0; l < LANES; l++)
        if (!dqm[l]) mem[wrCol][l] <= wrData[l*8 +: 8];
    end
  end

  // First stage of the mask pipeline; the lane output register is the second
  always_ff @(posedge clk) begin
    if (!rstN) mskD1 <= '0;
    else       mskD1 <= dqm;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] laneQ;
    logic       laneOe;
    always_ff @(posedge clk) begin
      if (!rstN || strb.kill || !strb.fire) begin
        laneQ  <= '0;
        laneOe <= 1'b0;
      end else if (mskD1[l]) begin
        laneQ  <= '0;
        laneOe <= 1'b0;
      end else begin
        laneQ  <= mem[rdCol][l];
        laneOe <= 1'b1;
      end
    end
    assign dqOut[l*8 +: 8] = laneQ;
    assign dqOe[l]         = laneOe;
  end

endmodule

// File: rtl/sdr_cas_read_path.sv
module sdr_cas_read_path
  import sdr_rd_pkg::*;
#(
  parameter int COL_W     = 4,
  parameter int LANES     = 2,
  parameter int BURST_LEN = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic               cmdWrite,
  input  logic [COL_W-1:0]   cmdCol,
  input  logic [2:0]         casCode,
  input  logic [LANES-1:0]   dqm,
  input  logic [LANES*8-1:0] wrData,
  output logic [LANES*8-1:0] dqOut,
  output logic [LANES-1:0]   dqOe
);

  rdStrobe_t        strb;
  logic [COL_W-1:0] rdCol;

  sdr_rd_ctrl #(.COL_W(COL_W), .BURST_LEN(BURST_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .cmdCol(cmdCol), .casCode(casCode), .strb(strb), .rdCol(rdCol)
  );

  sdr_rd_data #(.COL_W(COL_W), .LANES(LANES)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .rdCol(rdCol), .wrCol(cmdCol),
    .wrData(wrData), .dqm(dqm), .dqOut(dqOut), .dqOe(dqOe)
  );

endmodule

// File: rtl/sdr_cas_read_path_chk.sv
module sdr_cas_read_path_chk #(
  parameter int LANES     = 2,
  parameter int BURST_LEN = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic             cmdWrite,
  input logic [LANES-1:0] dqm,
  input logic [LANES-1:0] dqOe
);

  // Edges since the last READ, saturating
  logic [7:0] sinceRd;
  always_ff @(posedge clk) begin
    if (!rstN)                      sinceRd <= 8'hFF;
    else if (cmdValid && !cmdWrite) sinceRd <= 8'h00;
    else if (sinceRd != 8'hFF)      sinceRd <= sinceRd + 8'h01;
  end

  // R1: the bus is quiet on the first cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (dqOe == '0));

  // R5: no lane is enabled after the longest latency plus a full burst
  a_r5_bus_released: assert property (@(posedge clk) disable iff (!rstN)
    (dqOe != '0) |-> (sinceRd <= 8'(BURST_LEN + 1)));

  // R8: a mask bit sampled two edges ago keeps its lane off
  a_r8_mask_blanks: assert property (@(posedge clk) disable iff (!rstN)
    (($past(dqm, 2) & dqOe) == '0));

  // R10: a WRITE blanks every lane on the next cycle
  a_r10_write_blanks: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdWrite) |=> (dqOe == '0));

endmodule

bind sdr_cas_read_path sdr_cas_read_path_chk #(.LANES(LANES), .BURST_LEN(BURST_LEN)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
  .dqm(dqm), .dqOe(dqOe)
);

// File: tb/test_sdr_cas_read_path.sv
module test_sdr_cas_read_path;

  localparam int CLK_PERIOD = 10;
  localparam int BL = 4;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cmdValid, cmdWrite;
  logic [3:0]  cmdCol;
  logic [2:0]  casCode;
  logic [1:0]  dqm;
  logic [15:0] wrData;
  logic [15:0] dqOut;
  logic [1:0]  dqOe;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdr_cas_read_path i_sdr_cas_read_path (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .cmdCol(cmdCol), .casCode(casCode), .dqm(dqm), .wrData(wrData),
    .dqOut(dqOut), .dqOe(dqOe)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [15:0] shadow [16];

  // R4: column of word k inside the aligned block of four
  function automatic logic [3:0] colOf(input logic [3:0] base, input int k);
    return {base[3:2], 2'(base[1:0] + 2'(k))};
  endfunction

  task automatic checkBus(input string req, input int t, input logic [1:0] eOe, input logic [15:0] eDq);
    checks++;
    if (dqOe !== eOe || dqOut !== eDq) begin
      failures++;
      $display("FAIL %s t=%0d: oe=%b dq=%h expected oe=%b dq=%h", req, t, dqOe, dqOut, eOe, eDq);
    end
  endtask

  // One scenario: READ A at t=0, optional READ B at t=gap, optional mask pulse, optional WRITE
  task automatic scen(input string req,
                      input logic [2:0] codeA, input int la, input logic [3:0] colA,
                      input bit useB, input int gap, input logic [2:0] codeB, input int lb,
                      input logic [3:0] colB,
                      input int maskT, input logic [1:0] maskV, input int wrT);
    int LA = la - 1;
    int LB = gap + lb - 1;
    int T  = (useB ? LB : LA) + BL + 2;
    for (int t = 0; t < T; t++) begin
      cmdValid = (t == 0) || (useB && t == gap) || (t == wrT);
      cmdWrite = (t == wrT);
      cmdCol   = (t == wrT) ? 4'hF : ((useB && t == gap) ? colB : colA);
      wrData   = 16'hC3A5;
      dqm      = (t == maskT) ? maskV : 2'b00;
      if (t == wrT) dqm = 2'b00;
      casCode  = (t == 0) ? codeA : codeB;
      @(negedge clk);
      if (t == wrT) shadow[15] = 16'hC3A5;
      begin
        bit valid = 0;
        logic [3:0] c = '0;
        logic [1:0] eOe;
        logic [15:0] eDq;
        if (useB && t >= LB && t < LB + BL) begin
          valid = 1; c = colOf(colB, t - LB);
        end else if (t >= LA && t < LA + BL && !(useB && t >= LB)) begin
          valid = 1; c = colOf(colA, t - LA);
        end
        if (wrT >= 0 && t >= wrT) valid = 0;
        for (int l = 0; l < 2; l++) begin
          eOe[l] = valid && !(maskT >= 0 && t == maskT + 1 && maskV[l]);
          eDq[l*8 +: 8] = eOe[l] ? shadow[c][l*8 +: 8] : 8'h00;
        end
        checkBus(req, t, eOe, eDq);
      end
    end
    cmdValid = 0; cmdWrite = 0; dqm = 2'b00;
  endtask

  // R9: masked write, shadow updated by the lane rule; R10: bus off afterwards
  task automatic doWrite(input logic [3:0] col, input logic [15:0] data, input logic [1:0] mask);
    cmdValid = 1; cmdWrite = 1; cmdCol = col; wrData = data; dqm = mask;
    @(negedge clk);
    for (int l = 0; l < 2; l++)
      if (!mask[l]) shadow[col][l*8 +: 8] = data[l*8 +: 8];
    checkBus("R9 R10", 0, 2'b00, 16'h0000);
    cmdValid = 0; cmdWrite = 0; dqm = 2'b00;
  endtask

  initial begin
    for (int c = 0; c < 16; c++)   // R11: reset image of the array
      shadow[c] = {8'(16 + c), 8'(c)};
    rstN = 0; cmdValid = 0; cmdWrite = 0; cmdCol = 0; casCode = 3'b010;
    dqm = 0; wrData = 0;
    repeat (3) @(negedge clk);
    checkBus("R1", -1, 2'b00, 16'h0000);
    rstN = 1;
    @(negedge clk);
    checkBus("R1", 0, 2'b00, 16'h0000);

    scen("R2 R4 R5 R11", 3'b010, 2, 4'd5, 0, 0, 3'b010, 2, 4'd0, -1, 2'b00, -1);
    scen("R2 R4", 3'b011, 3, 4'd10, 0, 0, 3'b011, 3, 4'd0, -1, 2'b00, -1);
    scen("R3", 3'b110, 3, 4'd13, 0, 0, 3'b110, 3, 4'd0, -1, 2'b00, -1);
    scen("R3", 3'b010, 2, 4'd2, 0, 0, 3'b010, 2, 4'd0, -1, 2'b00, -1);
    scen("R3", 3'b000, 2, 4'd14, 0, 0, 3'b000, 2, 4'd0, -1, 2'b00, -1);
    scen("R6", 3'b010, 2, 4'd0, 1, 2, 3'b010, 2, 4'd9, -1, 2'b00, -1);
    scen("R6", 3'b011, 3, 4'd3, 1, 1, 3'b011, 3, 4'd12, -1, 2'b00, -1);
    scen("R7", 3'b011, 3, 4'd2, 1, 3, 3'b010, 2, 4'd6, -1, 2'b00, -1);
    scen("R8", 3'b010, 2, 4'd6, 0, 0, 3'b010, 2, 4'd0, 2, 2'b01, -1);
    scen("R8", 3'b011, 3, 4'd1, 0, 0, 3'b011, 3, 4'd0, 1, 2'b10, -1);
    doWrite(4'd7, 16'hBEEF, 2'b10);
    doWrite(4'd4, 16'h1357, 2'b00);
    doWrite(4'd5, 16'hFFFF, 2'b11);
    scen("R9", 3'b010, 2, 4'd4, 0, 0, 3'b010, 2, 4'd0, -1, 2'b00, -1);
    scen("R10", 3'b011, 3, 4'd8, 0, 0, 3'b011, 3, 4'd0, -1, 2'b00, 3);
    scen("R10", 3'b011, 3, 4'd9, 0, 0, 3'b011, 3, 4'd0, -1, 2'b00, 1);
    scen("R9 R10", 3'b010, 2, 4'd13, 0, 0, 3'b010, 2, 4'd0, -1, 2'b00, -1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired before the scenarios completed");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule